// File: doc/BRIEF.md
# Character Display Transmit Register Pair

This block sits between a processor's memory-mapped register bus and a character display. It exposes two 16-bit registers. The status register carries a ready flag and an interrupt-enable flag. The data register accepts the character to be shown. Address decoding is done outside the block. The block sees one write strobe per register, a shared write-data word, and a read-data word for each register.

Software polls the ready flag, or waits for the interrupt request, before it writes a character. An accepted write takes the low byte and sends it to the display sink. It does this with a single-cycle valid pulse, and it lowers the ready flag at the same time. The flag comes back when the sink signals that it has finished with a one-cycle done pulse. A write that arrives while the flag is low is dropped. It does not queue and it does not replace the character already handed over.

The asynchronous active-low reset is passed through a short synchronizer. Its release therefore reaches the registers on a clock edge.

Top module: `disp_xmit_regs`

## Requirements
- R1: After reset the status register reads 16'h8000 (ready = 1, interrupt enable = 0). The data register reads 16'h0000, the valid output is 0 and the interrupt request is 0.
- R2: Status read data carries ready in bit 15 and interrupt enable in bit 14. Bits 13:0 read as 0.
- R3: A data-register write made while ready is 1 is accepted. On the following cycle, ready reads 0.
- R4: An accepted write raises the valid output for exactly one cycle, on the cycle after the write. The character output carries bits 7:0 of the written word. Bits 15:8 of the word are ignored, and the data register reads back {8'h00, character}.
- R5: A data-register write made while ready is 0 is ignored. No valid pulse follows, and the character output and the data-register read value are unchanged.
- R6: A done pulse while ready is 0 sets ready to 1 on the next cycle. A done pulse while ready is already 1 has no effect.
- R7: A status-register write loads interrupt enable from bit 14 of the write word. All other bits of that write are ignored; in particular, ready cannot be changed by software.
- R8: The interrupt request is high exactly when ready and interrupt enable are both 1.
- R9: The character output holds the most recently accepted character until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stat_wr | input | 1 | Write strobe for the status register |
| data_wr | input | 1 | Write strobe for the data register |
| wdata | input | 16 | Write data shared by both registers |
| stat_rdata | output | 16 | Status register read value |
| data_rdata | output | 16 | Data register read value |
| disp_valid | output | 1 | One-cycle pulse handing a character to the display sink |
| disp_char | output | 8 | Character presented to the sink |
| disp_done | input | 1 | One-cycle pulse from the sink: it can take another character |
| irq | output | 1 | Interrupt request, ready and enable both set |

## Verification
The bench builds the block with its defaults: 16-bit registers, an 8-bit character, ready at bit 15, enable at bit 14 and a two-stage reset synchronizer. With these values the masking of the upper write byte can be observed, and so can the zeroed status bits between the two flags. Directed sequences cover several cases. They write while busy and send a done pulse while already idle. They write to the status register with every bit set and with every bit clear except enable. They also run chains of accepted characters, each released by a done pulse, which exercises the ready and interrupt handoff across many transfers.

// File: rtl/disp_xmit_pkg.sv
package disp_xmit_pkg;
  typedef struct packed {
    logic ready;
    logic ie;
  } disp_flags_t;

  localparam disp_flags_t FLAGS_RESET = '{ready: 1'b1, ie: 1'b0};
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/disp_flag_reg.sv
module disp_flag_reg
  import disp_xmit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        done,
  input  logic        stat_wr,
  input  logic        ie_wbit,
  output disp_flags_t flags_q
);
  disp_flags_t flags_d;
  logic        flags_en;

  always_comb begin
    flags_d = flags_q;
    if (accept)                  flags_d.ready = 1'b0;
    else if (done && !flags_q.ready) flags_d.ready = 1'b1;
    if (stat_wr)                 flags_d.ie = ie_wbit;
  end

  assign flags_en = accept | done | stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= FLAGS_RESET;
    else if (flags_en) flags_q <= flags_d;
  end

  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flags_q.ready && !accept) |=> flags_q.ready); // R6
  AST_READY_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.ready) |-> $past(done)); // R6
endmodule

// File: rtl/disp_char_chan.sv
module disp_char_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CHAR_W-1:0] char_in,
  output logic [CHAR_W-1:0] char_q,
  output logic              valid_q
);
  logic [CHAR_W-1:0] char_d;
  logic              valid_d;

  always_comb begin
    char_d  = accept ? char_in : char_q;
    valid_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      char_q <= '0;
    else if (accept) char_q <= char_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R4
  AST_CHAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(char_q)); // R9
endmodule

// File: rtl/disp_xmit_regs.sv
module disp_xmit_regs
  import disp_xmit_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int CHAR_W      = 8,
  parameter int RDY_POS     = 15,
  parameter int IE_POS      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic              data_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  stat_rdata,
  output logic [REG_W-1:0]  data_rdata,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  output logic              irq
);
  localparam int PAD_W = REG_W - CHAR_W;

  logic        rst_sync_n;
  disp_flags_t flags;
  logic        accept;
  logic        wdata_unused;

  assign wdata_unused = ^wdata;

  disp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept = data_wr & flags.ready;

  disp_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .done    (disp_done),
    .stat_wr (stat_wr),
    .ie_wbit (wdata[IE_POS]),
    .flags_q (flags)
  );

  disp_char_chan #(.CHAR_W(CHAR_W)) u_chan (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .char_in (wdata[CHAR_W-1:0]),
    .char_q  (disp_char),
    .valid_q (disp_valid)
  );

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[RDY_POS] = flags.ready;
    stat_rdata[IE_POS]  = flags.ie;
  end

  assign data_rdata = {{PAD_W{1'b0}}, disp_char};
  assign irq        = flags.ready & flags.ie;

  AST_ACCEPT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_wr && stat_rdata[RDY_POS]) |=> !stat_rdata[RDY_POS]); // R3
  AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_valid |-> $past(data_wr)); // R4
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_wr && !stat_rdata[RDY_POS]) |=> (!disp_valid && $stable(disp_char))); // R5
  AST_NO_IRQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_rdata[RDY_POS] |-> !irq); // R8
  AST_UPPER_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_rdata[REG_W-1:CHAR_W] == '0); // R4
endmodule

// File: tb/disp_xmit_regs_tb_top.sv
module disp_xmit_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] stat_rdata;
  logic [15:0] data_rdata;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_done = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  disp_xmit_regs dut_i (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .data_wr(data_wr),
    .wdata(wdata), .stat_rdata(stat_rdata), .data_rdata(data_rdata),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_done(disp_done),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_data(input logic [15:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0; wdata = '0;
  endtask

  task automatic write_stat(input logic [15:0] v);
    @(negedge clk); stat_wr = 1'b1; wdata = v;
    @(negedge clk); stat_wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); disp_done = 1'b1;
    @(negedge clk); disp_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(stat_rdata == 16'h8000, "R1 status", stat_rdata, 16'h8000);
    chk(data_rdata == 16'h0000, "R1 data", data_rdata, 16'h0000);
    chk(!disp_valid, "R1 valid", {15'd0, disp_valid}, 16'd0);
    chk(!irq, "R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_accept();
    write_data(16'hAB41);
    chk(disp_valid, "R4 valid pulse", {15'd0, disp_valid}, 16'd1);
    chk(disp_char == 8'h41, "R4 char", {8'd0, disp_char}, 16'h0041);
    chk(data_rdata == 16'h0041, "R4 upper byte dropped", data_rdata, 16'h0041);
    chk(stat_rdata == 16'h0000, "R3 ready cleared", stat_rdata, 16'h0000);
    @(negedge clk);
    chk(!disp_valid, "R4 single cycle", {15'd0, disp_valid}, 16'd0);
  endtask

  task automatic t_busy_write();
    write_data(16'h0055);
    chk(!disp_valid, "R5 no pulse", {15'd0, disp_valid}, 16'd0);
    chk(data_rdata == 16'h0041, "R5 data kept", data_rdata, 16'h0041);
    @(negedge clk);
    chk(disp_char == 8'h41, "R9 char held", {8'd0, disp_char}, 16'h0041);
  endtask

  task automatic t_done();
    pulse_done();
    chk(stat_rdata == 16'h8000, "R6 ready restored", stat_rdata, 16'h8000);
    pulse_done();
    chk(stat_rdata == 16'h8000, "R6 idle done no effect", stat_rdata, 16'h8000);
    chk(!disp_valid, "R6 idle done no pulse", {15'd0, disp_valid}, 16'd0);
  endtask

  task automatic t_enable();
    write_stat(16'hFFFF);
    chk(stat_rdata == 16'hC000, "R2 R7 status bits", stat_rdata, 16'hC000);
    chk(irq, "R8 irq set", {15'd0, irq}, 16'd1);
    write_data(16'h0033);
    chk(stat_rdata == 16'h4000, "R7 ready not writable path", stat_rdata, 16'h4000);
    chk(!irq, "R8 irq busy", {15'd0, irq}, 16'd0);
    write_stat(16'hBFFF);
    chk(stat_rdata == 16'h0000, "R7 ready unaffected by write", stat_rdata, 16'h0000);
    write_stat(16'h4000);
    pulse_done();
    chk(irq, "R8 irq after done", {15'd0, irq}, 16'd1);
    write_stat(16'h0000);
    chk(stat_rdata == 16'h8000, "R7 enable cleared", stat_rdata, 16'h8000);
    chk(!irq, "R8 irq masked", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_chain();
    for (int i = 0; i < 6; i++) begin
      logic [15:0] v;
      v = 16'h5A00 + 16'(i * 7 + 1);
      write_data(v);
      chk(disp_valid && disp_char == v[7:0], "R4 chain char", {8'd0, disp_char}, {8'd0, v[7:0]});
      write_data(16'h00FF);
      chk(disp_char == v[7:0], "R5 chain busy drop", {8'd0, disp_char}, {8'd0, v[7:0]});
      pulse_done();
      chk(stat_rdata[15], "R6 chain ready", stat_rdata, 16'h8000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_accept();
    t_busy_write();
    t_done();
    t_enable();
    t_chain();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule